// File: doc/BRIEF.md
# Frame-Locked Audio Sample Pacer

This block sets the audio sample rate on a serial codec link. It does not count bit clocks. It counts frame-sync pulses. A programmable modulus N sets the rate: one sample/convert strobe is issued on every Nth sync pulse. With 32 bit clocks per frame, that gives one sample every 32×N bit clocks. Because the block steps only on sync pulses, two copies can stay in lockstep. One copy sits on the host side and one on the codec side, and both watch the same decoded control-register write.

A control write turns the pacer on or off. Its two path bits enable the ADC path and the DAC path. A write with both bits clear is a stop request.
- A start takes effect as soon as the write arrives. Counting begins on the next sync pulse.
- A stop takes effect on the sync pulse that follows the write. On that pulse the counter stops and reloads the modulus.

On each strobe the block does two things:
- It latches the current ADC result into a holding register, which is shipped in the next outgoing frame.
- It loads the DAC data register from the head of the transmit FIFO and pops the FIFO. If the FIFO is empty, the DAC register keeps its last value, so the previous sample plays again.

Top module: `aud_rate_pacer`

## Requirements
- R1: After reset, `samp_o` and `pop_o` are low and `dac_o` and `adc_o` are zero. Sync pulses give no strobe until an enabling control write has arrived.
- R2: Once started with modulus N ≥ 1, the first strobe comes on the Nth sync pulse after the start write, and a strobe follows every N sync pulses after that. `samp_o` is high for exactly the one cycle after the clock edge that samples that sync pulse.
- R3: A start write takes effect in its own cycle. A sync pulse sampled before the write, or in the same cycle as the write, does not count toward the first period.
- R4: After a stop write (both path bits clear), the next sync pulse gives no strobe and stops the counter. Later sync pulses give no strobes. A new start runs a full N-pulse period.
- R5: A modulus of 0 acts as 1: there is a strobe on every sync pulse.
- R6: A modulus write while the pacer runs does not change the running period. It takes effect at the next start after a stop.
- R7: On a strobe with the ADC path bit set, `adc_o` takes the value of `adc_i` sampled at that sync edge. On a strobe with the ADC bit clear, `adc_o` is unchanged.
- R8: On a strobe with the DAC path bit set and `fifo_empty_i` low, `dac_o` takes `fifo_data_i` and `pop_o` pulses together with `samp_o`. If `fifo_empty_i` is high, `dac_o` keeps its value and `pop_o` stays low.
- R9: With the DAC path bit clear, a strobe gives no `pop_o`, and `dac_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame-sync pulse, one cycle wide |
| ctrl_wr_i | input | 1 | Decoded write to the codec control register |
| ctrl_adc_en_i | input | 1 | ADC path enable bit carried by the write |
| ctrl_dac_en_i | input | 1 | DAC path enable bit carried by the write |
| mod_wr_i | input | 1 | Modulus register write strobe |
| mod_i | input | MOD_W | Modulus value (0 is treated as 1) |
| fifo_empty_i | input | 1 | Transmit FIFO empty flag |
| fifo_data_i | input | DATA_W | Transmit FIFO head sample |
| adc_i | input | DATA_W | Converted ADC result |
| samp_o | output | 1 | Sample/convert strobe, one cycle |
| pop_o | output | 1 | Transmit FIFO pop strobe |
| dac_o | output | DATA_W | DAC data register |
| adc_o | output | DATA_W | ADC holding register for the next frame |

## Verification
The bench builds the block with MOD_W = 4 and DATA_W = 16. The narrow modulus makes both the largest value (15) and the zero case reachable within a few dozen sync pulses, so the full period range is swept in one run. The wide data path lets distinct FIFO and ADC words show whether a register was loaded, held or repeated.

// File: rtl/aud_rate_pkg.sv
package aud_rate_pkg;
  typedef struct packed {
    logic adc;
    logic dac;
  } path_t;
endpackage

// File: rtl/aud_rate_ctrl.sv
module aud_rate_ctrl
  import aud_rate_pkg::*;
#(
  parameter int unsigned MOD_W   = 7,
  parameter int unsigned MOD_RST = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             ctrl_wr_i,
  input  path_t            ctrl_path_i,
  input  logic             mod_wr_i,
  input  logic [MOD_W-1:0] mod_i,
  output logic             run_o,
  output logic             tick_o,
  output path_t            path_o,
  output logic [MOD_W-1:0] mod_o,
  output logic [MOD_W-1:0] act_mod_o
);
  logic             run_q, stop_q;
  path_t            path_q;
  logic [MOD_W-1:0] mod_q, act_q;
  logic             start_req;

  assign start_req = ctrl_wr_i && (ctrl_path_i.adc || ctrl_path_i.dac);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q <= MOD_W'(MOD_RST);
    end else if (mod_wr_i) begin
      mod_q <= mod_i;
    end
  end

  // start acts at once; stop waits for the next sync
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      path_q <= '0;
      act_q  <= MOD_W'(MOD_RST);
    end else if (start_req) begin
      if (!run_q) begin
        run_q <= 1'b1;
        act_q <= mod_q;
      end
      stop_q <= 1'b0;
      path_q <= ctrl_path_i;
    end else if (ctrl_wr_i) begin
      if (run_q) stop_q <= 1'b1;
    end else if (sync_i && stop_q) begin
      run_q  <= 1'b0;
      stop_q <= 1'b0;
      path_q <= '0;
    end
  end

  assign run_o     = run_q;
  assign tick_o    = sync_i && run_q && !stop_q && !ctrl_wr_i;
  assign path_o    = path_q;
  assign mod_o     = mod_q;
  assign act_mod_o = act_q;
endmodule

// File: rtl/aud_rate_cnt.sv
module aud_rate_cnt #(
  parameter int unsigned MOD_W   = 7,
  parameter int unsigned MOD_RST = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [MOD_W-1:0] idle_mod_i,
  input  logic [MOD_W-1:0] run_mod_i,
  output logic             hit_o
);
  localparam logic [MOD_W-1:0] ONE = MOD_W'(1);

  logic [MOD_W-1:0] cnt_q, idle_eff, run_eff;

  // modulus 0 behaves as 1
  assign idle_eff = (idle_mod_i == '0) ? ONE : idle_mod_i;
  assign run_eff  = (run_mod_i  == '0) ? ONE : run_mod_i;
  assign hit_o    = tick_i && (cnt_q == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= (MOD_RST == 0) ? ONE : MOD_W'(MOD_RST);
    end else if (!run_i) begin
      cnt_q <= idle_eff;
    end else if (tick_i) begin
      cnt_q <= hit_o ? run_eff : cnt_q - ONE;
    end
  end
endmodule

// File: rtl/aud_rate_dp.sv
module aud_rate_dp
  import aud_rate_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  path_t             path_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic [DATA_W-1:0] adc_i,
  output logic              samp_o,
  output logic              pop_o,
  output logic [DATA_W-1:0] dac_o,
  output logic [DATA_W-1:0] adc_o
);
  logic              samp_q, pop_q, take_dac;
  logic [DATA_W-1:0] dac_q, adc_q;

  assign take_dac = hit_i && path_i.dac && !fifo_empty_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= 1'b0;
      pop_q  <= 1'b0;
      dac_q  <= '0;
      adc_q  <= '0;
    end else begin
      samp_q <= hit_i;
      pop_q  <= take_dac;
      if (take_dac)              dac_q <= fifo_data_i;
      if (hit_i && path_i.adc)   adc_q <= adc_i;
    end
  end

  assign samp_o = samp_q;
  assign pop_o  = pop_q;
  assign dac_o  = dac_q;
  assign adc_o  = adc_q;
endmodule

// File: rtl/aud_rate_pacer.sv
module aud_rate_pacer
  import aud_rate_pkg::*;
#(
  parameter int unsigned MOD_W   = 7,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MOD_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_adc_en_i,
  input  logic              ctrl_dac_en_i,
  input  logic              mod_wr_i,
  input  logic [MOD_W-1:0]  mod_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic [DATA_W-1:0] adc_i,
  output logic              samp_o,
  output logic              pop_o,
  output logic [DATA_W-1:0] dac_o,
  output logic [DATA_W-1:0] adc_o
);
  path_t            ctrl_path, path_w;
  logic             run_w, tick_w, hit_w;
  logic [MOD_W-1:0] mod_w, act_mod_w;

  assign ctrl_path = '{adc: ctrl_adc_en_i, dac: ctrl_dac_en_i};

  aud_rate_ctrl #(.MOD_W(MOD_W), .MOD_RST(MOD_RST)) u_ctrl (
    .clk_i, .rst_ni, .sync_i, .ctrl_wr_i,
    .ctrl_path_i(ctrl_path), .mod_wr_i, .mod_i,
    .run_o(run_w), .tick_o(tick_w), .path_o(path_w),
    .mod_o(mod_w), .act_mod_o(act_mod_w)
  );

  aud_rate_cnt #(.MOD_W(MOD_W), .MOD_RST(MOD_RST)) u_cnt (
    .clk_i, .rst_ni, .run_i(run_w), .tick_i(tick_w),
    .idle_mod_i(mod_w), .run_mod_i(act_mod_w), .hit_o(hit_w)
  );

  aud_rate_dp #(.DATA_W(DATA_W)) u_dp (
    .clk_i, .rst_ni, .hit_i(hit_w), .path_i(path_w),
    .fifo_empty_i, .fifo_data_i, .adc_i,
    .samp_o, .pop_o, .dac_o, .adc_o
  );
endmodule

// File: rtl/aud_rate_pacer_chk.sv
module aud_rate_pacer_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              run_i,
  input logic              fifo_empty_i,
  input logic              samp_o,
  input logic              pop_o,
  input logic [DATA_W-1:0] dac_o,
  input logic [DATA_W-1:0] adc_o
);
  AST_SAMP_AFTER_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o |-> $past(sync_i)); // R2
  AST_IDLE_NO_SAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !samp_o); // R4
  AST_POP_WITH_SAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> samp_o); // R8
  AST_POP_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> $past(!fifo_empty_i)); // R8
  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_o |-> $stable(dac_o)); // R9
  AST_ADC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !samp_o |-> $stable(adc_o)); // R7
endmodule

bind aud_rate_pacer aud_rate_pacer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .run_i(run_w),
  .fifo_empty_i(fifo_empty_i), .samp_o(samp_o), .pop_o(pop_o),
  .dac_o(dac_o), .adc_o(adc_o)
);

// File: tb/aud_rate_pacer_bench.sv
module aud_rate_pacer_bench;
  localparam int MOD_W  = 4;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [3:0] m;
    logic       adc;
    logic       dac;
    logic [5:0] n;
    logic [5:0] exp_cnt;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  1'b1, 1'b0, 6'd9,  6'd3},
    '{4'd1,  1'b0, 1'b1, 6'd5,  6'd5},
    '{4'd0,  1'b1, 1'b1, 6'd4,  6'd4},
    '{4'd15, 1'b1, 1'b0, 6'd31, 6'd2},
    '{4'd5,  1'b0, 1'b1, 6'd12, 6'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync = 1'b0, cwr = 1'b0, cadc = 1'b0, cdac = 1'b0, mwr = 1'b0;
  logic [MOD_W-1:0]  mval = '0;
  logic              fempty = 1'b1;
  logic [DATA_W-1:0] fdata = '0, adcv = '0;
  logic              samp, pop;
  logic [DATA_W-1:0] dac, adcq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  aud_rate_pacer #(.MOD_W(MOD_W), .DATA_W(DATA_W)) u_aud_rate_pacer (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .ctrl_wr_i(cwr),
    .ctrl_adc_en_i(cadc), .ctrl_dac_en_i(cdac), .mod_wr_i(mwr), .mod_i(mval),
    .fifo_empty_i(fempty), .fifo_data_i(fdata), .adc_i(adcv),
    .samp_o(samp), .pop_o(pop), .dac_o(dac), .adc_o(adcq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic a, input logic d);
    cwr = 1'b1; cadc = a; cdac = d;
    @(negedge clk);
    cwr = 1'b0; cadc = 1'b0; cdac = 1'b0;
  endtask

  task automatic mod_write(input logic [MOD_W-1:0] v);
    mwr = 1'b1; mval = v;
    @(negedge clk);
    mwr = 1'b0;
  endtask

  // one frame: sync pulse, sample outputs one edge later, idle gap
  task automatic frame(output logic s, output logic p);
    sync = 1'b1;
    @(negedge clk);
    sync = 1'b0;
    s = samp; p = pop;
    repeat (3) @(negedge clk);
  endtask

  task automatic stop_run();
    logic s, p;
    ctrl_write(1'b0, 1'b0);
    frame(s, p);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic s, p;
    int scnt, first, pcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, idle syncs do nothing
    chk("R1 samp", samp, 0);
    chk("R1 pop", pop, 0);
    chk("R1 dac", dac, 0);
    chk("R1 adc", adcq, 0);
    scnt = 0;
    for (int k = 0; k < 4; k++) begin frame(s, p); if (s) scnt++; end
    chk("R1 idle strobes", scnt, 0);

    // vector table: R2 period, R5 zero modulus, R8 pops track strobes
    fempty = 1'b0;
    for (int v = 0; v < NV; v++) begin
      mod_write(VECS[v].m);
      ctrl_write(VECS[v].adc, VECS[v].dac);
      scnt = 0; first = 0; pcnt = 0;
      for (int k = 1; k <= int'(VECS[v].n); k++) begin
        fdata = DATA_W'(16'h1000 + k);
        frame(s, p);
        if (s) begin scnt++; if (first == 0) first = k; end
        if (p) pcnt++;
      end
      chk("R2 R5 strobe count", scnt, VECS[v].exp_cnt);
      chk("R2 R3 first strobe", first, (VECS[v].m == 0) ? 1 : VECS[v].m);
      chk("R8 R9 pop count", pcnt, VECS[v].dac ? VECS[v].exp_cnt : 0);
      stop_run();
    end

    // R3: sync in the same cycle as the start write does not count
    mod_write(4'd2);
    cwr = 1'b1; cadc = 1'b1; sync = 1'b1;
    @(negedge clk);
    cwr = 1'b0; cadc = 1'b0; sync = 1'b0;
    chk("R3 no strobe on write cycle", samp, 0);
    repeat (3) @(negedge clk);
    frame(s, p); chk("R3 sync 1", s, 0);
    frame(s, p); chk("R3 sync 2", s, 1);
    stop_run();

    // R4: stop before the period ends, then full period on restart
    mod_write(4'd2);
    ctrl_write(1'b1, 1'b0);
    frame(s, p);
    ctrl_write(1'b0, 1'b0);
    frame(s, p); chk("R4 stop sync", s, 0);
    scnt = 0;
    for (int k = 0; k < 3; k++) begin frame(s, p); if (s) scnt++; end
    chk("R4 stopped", scnt, 0);
    ctrl_write(1'b1, 1'b0);
    frame(s, p); chk("R4 restart sync 1", s, 0);
    frame(s, p); chk("R4 restart sync 2", s, 1);

    // R6: modulus write while running is held off
    mod_write(4'd4);
    frame(s, p); chk("R6 running sync 1", s, 0);
    frame(s, p); chk("R6 running sync 2", s, 1);
    stop_run();
    ctrl_write(1'b1, 1'b0);
    scnt = 0; first = 0;
    for (int k = 1; k <= 4; k++) begin frame(s, p); if (s && first == 0) first = k; end
    chk("R6 new period", first, 4);
    stop_run();

    // R7: ADC latch gated by ADC path bit
    mod_write(4'd1);
    fempty = 1'b1;
    adcv = 16'h00A5;
    ctrl_write(1'b1, 1'b0);
    frame(s, p); chk("R7 adc load", adcq, 16'h00A5);
    stop_run();
    adcv = 16'h005A;
    ctrl_write(1'b0, 1'b1);
    frame(s, p); chk("R7 strobe", s, 1);
    chk("R7 adc held", adcq, 16'h00A5);
    stop_run();

    // R8: load from FIFO, then repeat when empty
    fempty = 1'b0; fdata = 16'h1234;
    ctrl_write(1'b0, 1'b1);
    frame(s, p); chk("R8 pop", p, 1);
    chk("R8 dac load", dac, 16'h1234);
    fempty = 1'b1; fdata = 16'hBEEF;
    frame(s, p); chk("R8 empty no pop", p, 0);
    chk("R8 empty repeat", dac, 16'h1234);
    stop_run();

    // R9: DAC path off
    fempty = 1'b0; fdata = 16'h7777;
    ctrl_write(1'b1, 1'b0);
    frame(s, p); chk("R9 strobe", s, 1);
    chk("R9 no pop", p, 0);
    chk("R9 dac held", dac, 16'h1234);
    stop_run();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule